// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block connects a register-mapped host to one PS/2 device, either a keyboard or a pointing device. Two copies of the same design serve the two ports. The host reads and writes four byte-wide registers: status, control, transmit data and receive data. The block samples the open-drain clock and data lines and drives them low through enable outputs.

Frames from the device are 11 bits long: a low start bit, eight data bits with the least significant bit first, an odd parity bit and a high stop bit. Each bit is taken on a falling clock edge. The block reports bad parity, a bad stop bit and a frame that stops part way through. To send a byte, the host writes it to the transmit register. The block holds the clock low, places the start bit and releases the clock. It then shifts the byte out on the edges the device generates. Control bits can hold the clock low to pause the device, either always or only after each transmit.

The clock and data inputs each pass through a two-stage synchronizer and a majority-free glitch filter before edge detection. The filter changes its output only after FILTER_LEN equal samples.

Top module: `ps2_host_port`

## Requirements
- R1: After rst_n is released, control reads 0x00 and irq is low. Once the input filter has settled, status reads 0x0A: the clock is driven low and the transmit buffer is empty.
- R2: The register map is as follows.
  - Address 0 is status. Bit0 is the filtered clock line, bit1 the clock drive-low output, bit2 transmit busy, bit3 transmit empty, bit4 receive full, bit5 receive busy, bit6 parity error and bit7 framing error.
  - Address 1 is control. Bit0 holds the clock after a transmit, bit1 is transmit enable, bit2 transmit interrupt enable, bit3 receive interrupt enable, bit4 receive clock enable and bit5 port reset. Control reads back as written.
  - Address 2 is transmit data.
  - Address 3 is receive data.
- R3: A device frame taken on falling clock edges loads its eight data bits, least significant bit first, into the receive-data register and sets receive-full.
- R4: Parity is odd over the data bits and the parity bit. A mismatch sets the parity-error bit, and the byte is still delivered.
- R5: A stop bit sampled low sets the framing-error bit and leaves receive-full clear.
- R6: If a frame is in progress and no clock edge arrives for TIMEOUT_CYCLES cycles, the partial frame is dropped, the framing-error bit is set and receive-busy clears. The next frame is received normally.
- R7: A read of address 3 with reg_rd clears receive-full, parity-error and framing-error.
- R8: A write to address 2 is taken only while transmit-empty is 1 and transmit enable is 1. Any other write to it changes nothing and starts no transfer.
- R9: A transmit runs in this order:
  - the clock is held low for at least INHIBIT_CYCLES cycles;
  - data is driven low as the start bit, and the clock is released;
  - on each falling edge from the device, the next bit goes out: the data bits least significant first, then the odd parity bit, then a released stop bit;
  - the 11th falling edge, the acknowledge, ends the transfer. Transmit-empty then sets and transmit-busy clears.
- R10: With control bit0 set, the clock is held low once a transmit ends. The hold lasts until bit0 is written as 0.
- R11: With control bit4 at 0 and no transmit running, the clock is held low.
- R12: With control bit5 set, both buffers are emptied, both error flags are cleared, transmit and receive are idle, data is released and the clock is held low.
- R13: irq is high when receive-full and receive interrupt enable are both set, or when transmit-empty and transmit interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; acts on address 3 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt |
| ps2_clk_i | input | 1 | PS/2 clock line as seen on the pin |
| ps2_dat_i | input | 1 | PS/2 data line as seen on the pin |
| ps2_clk_oe | output | 1 | Drive the clock line low |
| ps2_dat_oe | output | 1 | Drive the data line low |

## Verification
The bench builds the block with the following values:
- FILTER_LEN = 3;
- INHIBIT_CYCLES = 40, in place of the 100 µs default;
- TIMEOUT_CYCLES = 300, in place of the roughly 2 ms default.

With these values a full host-side transfer takes about 500 cycles. A stalled frame times out within a few hundred cycles, so the abort and recovery path is exercised directly. A device half-period of 20 cycles is well inside the timeout window. It is also long enough that the synchronizer and filter delay, about 5 cycles, never mixes up adjacent bits.

// File: rtl/ps2_host_port.sv
module ps2_host_port #(
  parameter int FILTER_LEN     = 3,
  parameter int INHIBIT_CYCLES = 12500,
  parameter int TIMEOUT_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe
);
  localparam int IW = $clog2(INHIBIT_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [1:0] A_STAT = 2'd0, A_CTRL = 2'd1, A_TX = 2'd2, A_RX = 2'd3;

  typedef enum logic [1:0] {T_IDLE, T_INH, T_START, T_SHIFT} tx_state_t;

  logic [1:0] clk_sync, dat_sync;
  logic [FILTER_LEN-1:0] clk_hist, dat_hist;
  logic clk_f, dat_f;

  logic [5:0] ctrl;
  logic [3:0] rx_cnt;
  logic [8:0] rx_sr;
  logic [7:0] rx_data;
  logic rx_full, par_err, frm_err;
  tx_state_t tx_st;
  logic [3:0] tx_cnt;
  logic [8:0] tx_sr;
  logic tx_drive, tx_empty, post_inh;
  logic [IW-1:0] inh_cnt;
  logic [TW-1:0] to_cnt;

  wire clk_fall = clk_f & ~|clk_hist;
  wire clk_rise = ~clk_f & &clk_hist;
  wire tx_busy  = tx_st != T_IDLE;
  wire busy     = (rx_cnt != 4'd0) || (tx_st == T_SHIFT);
  wire to_hit   = to_cnt == TW'(TIMEOUT_CYCLES);
  wire clk_hold = ctrl[5] || tx_st == T_INH || tx_st == T_START ||
                  (tx_st == T_IDLE && (!ctrl[4] || post_inh));
  wire tx_take  = reg_wr && reg_addr == A_TX && tx_empty && ctrl[1];

  assign ps2_clk_oe = clk_hold;
  assign ps2_dat_oe = tx_drive;
  assign irq = (rx_full && ctrl[3]) || (tx_empty && ctrl[2]);

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {frm_err, par_err, rx_cnt != 4'd0, rx_full,
                            tx_empty, tx_busy, ps2_clk_oe, clk_f};
      A_CTRL:  reg_rdata = {2'b00, ctrl};
      A_RX:    reg_rdata = rx_data;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '1; dat_sync <= '1;
      clk_hist <= '1; dat_hist <= '1;
      clk_f    <= 1'b1; dat_f <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[0], ps2_clk_i};
      dat_sync <= {dat_sync[0], ps2_dat_i};
      clk_hist <= {clk_hist[FILTER_LEN-2:0], clk_sync[1]};
      dat_hist <= {dat_hist[FILTER_LEN-2:0], dat_sync[1]};
      if (&clk_hist) clk_f <= 1'b1; else if (~|clk_hist) clk_f <= 1'b0;
      if (&dat_hist) dat_f <= 1'b1; else if (~|dat_hist) dat_f <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; rx_cnt <= '0; rx_sr <= '0; rx_data <= '0;
      rx_full <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
      tx_st <= T_IDLE; tx_cnt <= '0; tx_sr <= '0; tx_drive <= 1'b0;
      tx_empty <= 1'b1; post_inh <= 1'b0; inh_cnt <= '0; to_cnt <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        ctrl <= reg_wdata[5:0];
        if (!reg_wdata[0]) post_inh <= 1'b0;
      end
      if (ctrl[5]) begin
        rx_cnt <= '0; rx_full <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
        tx_st <= T_IDLE; tx_drive <= 1'b0; tx_empty <= 1'b1;
        post_inh <= 1'b0; to_cnt <= '0;
      end else begin
        to_cnt <= (busy && !(clk_fall || clk_rise) && !to_hit) ? to_cnt + 1'b1 : '0;
        if (reg_rd && reg_addr == A_RX) begin
          rx_full <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
        end
        if (tx_take) begin
          tx_sr    <= {~^reg_wdata, reg_wdata};
          tx_empty <= 1'b0;
        end

        if (to_hit && rx_cnt != 4'd0) begin
          rx_cnt  <= '0;
          frm_err <= 1'b1;
        end else if (clk_fall && tx_st == T_IDLE && !clk_hold) begin
          if (rx_cnt == 4'd0) begin
            if (!dat_f) rx_cnt <= 4'd1;
          end else if (rx_cnt == 4'd10) begin
            rx_cnt <= '0;
            if (dat_f) begin
              rx_data <= rx_sr[7:0];
              rx_full <= 1'b1;
              par_err <= ~^rx_sr;
            end else begin
              frm_err <= 1'b1;
            end
          end else begin
            rx_sr  <= {dat_f, rx_sr[8:1]};
            rx_cnt <= rx_cnt + 4'd1;
          end
        end

        case (tx_st)
          T_IDLE: if (!tx_empty && rx_cnt == 4'd0) begin
            tx_st <= T_INH; inh_cnt <= '0; post_inh <= 1'b0;
          end
          T_INH: if (inh_cnt == IW'(INHIBIT_CYCLES - 1)) begin
            tx_st <= T_START; tx_drive <= 1'b1;
          end else inh_cnt <= inh_cnt + 1'b1;
          T_START: begin tx_st <= T_SHIFT; tx_cnt <= '0; end
          default: if (to_hit) begin
            tx_st <= T_IDLE; tx_drive <= 1'b0; tx_empty <= 1'b1;
          end else if (clk_fall) begin
            tx_cnt <= tx_cnt + 4'd1;
            if (tx_cnt < 4'd9) begin
              tx_drive <= ~tx_sr[0];
              tx_sr    <= {1'b0, tx_sr[8:1]};
            end else if (tx_cnt == 4'd9) begin
              tx_drive <= 1'b0;
            end else begin
              tx_st <= T_IDLE; tx_empty <= 1'b1; post_inh <= ctrl[0];
            end
          end
        endcase
      end
    end
  end
endmodule

module ps2_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [5:0] ctrl_q,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       par_err,
  input logic       frm_err,
  input logic [3:0] rx_cnt,
  input logic       tx_busy,
  input logic       ps2_dat_oe
);
  // R12
  port_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[5] |=> tx_empty && !rx_full && !par_err && !frm_err && !tx_busy && !ps2_dat_oe);
  // R8
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd2 && tx_empty && ctrl_q[1] && !ctrl_q[5] |=> !tx_empty);
  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 2'd3 && rx_cnt != 4'd10 |=> !rx_full && !par_err);
  // R9
  dat_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_dat_oe |-> tx_busy);
  // R3
  full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_cnt) == 4'd10);
endmodule

bind ps2_host_port ps2_host_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .ctrl_q(ctrl), .tx_empty(tx_empty), .rx_full(rx_full), .par_err(par_err),
  .frm_err(frm_err), .rx_cnt(rx_cnt), .tx_busy(tx_busy), .ps2_dat_oe(ps2_dat_oe)
);

// File: tb/test_ps2_host_port.sv
module test_ps2_host_port;
  localparam int FLEN = 3, INH = 40, TO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, ps2_clk_oe, ps2_dat_oe;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  wire ps2_clk = ~ps2_clk_oe & dev_clk;
  wire ps2_dat = ~ps2_dat_oe & dev_dat;
  int nchk = 0, nfail = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  ps2_host_port #(.FILTER_LEN(FLEN), .INHIBIT_CYCLES(INH), .TIMEOUT_CYCLES(TO)) i_ps2_host_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat), .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe));

  function automatic logic odd_par(logic [7:0] b);
    return ~^b;
  endfunction

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic finish_test();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); reg_addr = 2'd3; #1 d = reg_rdata; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic dev_bit(logic v);
    dev_dat = v; wcyc(8); dev_clk = 1'b0; wcyc(20); dev_clk = 1'b1; wcyc(12);
  endtask

  task automatic dev_send(logic [7:0] b, logic bad_par, logic stop_v);
    logic [10:0] f;
    while (ps2_clk_oe) @(negedge clk);
    f = {stop_v, odd_par(b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) dev_bit(f[i]);
    dev_dat = 1'b1;
    wcyc(20);
  endtask

  task automatic dev_recv(output logic [7:0] d, output logic par, output logic stp, output int held);
    logic [10:0] b;
    logic [7:0] s;
    held = 0;
    while (!ps2_clk_oe) @(negedge clk);
    while (ps2_clk_oe) begin held++; @(negedge clk); end
    chk("R9 start bit driven", ps2_dat_oe, 1);
    peek(2'd0, s);
    chk("R9 busy while sending", s & 8'h0C, 8'h04);
    wcyc(8);
    for (int k = 1; k <= 10; k++) begin
      dev_clk = 1'b0; wcyc(20); dev_clk = 1'b1;
      b[k] = ps2_dat; wcyc(20);
    end
    dev_dat = 1'b0; wcyc(5); dev_clk = 1'b0; wcyc(20); dev_clk = 1'b1;
    wcyc(5); dev_dat = 1'b1; wcyc(20);
    b[0] = 1'b0;
    d = b[8:1]; par = b[9]; stp = b[10];
  endtask

  task automatic tx_check(logic [7:0] v, string req);
    logic [7:0] d, s;
    logic p, st;
    int held;
    dev_recv(d, p, st, held);
    chk(req, d, v);
    chk("R9 parity bit", p, odd_par(v));
    chk("R9 stop released", st, 1);
    chk("R9 inhibit long enough", held >= INH, 1);
    peek(2'd0, s);
    chk("R9 empty after ack", s & 8'h0C, 8'h08);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_test();
  end

  initial begin
    logic [7:0] v, d;
    int unused;
    unused = $urandom(32'd2024);
    wcyc(5); rst_n = 1'b1; wcyc(12);

    peek(2'd0, v); chk("R1 status after reset", v, 8'h0A);
    peek(2'd1, v); chk("R1 control after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R11 clock held while rx clock disabled", ps2_clk_oe, 1);

    wr(2'd1, 8'h12); wcyc(10);
    peek(2'd0, v); chk("R2 status idle layout", v, 8'h09);
    peek(2'd1, v); chk("R2 control readback", v, 8'h12);

    dev_send(8'hA5, 1'b0, 1'b1); wcyc(5);
    peek(2'd0, v); chk("R3 rx full status", v, 8'h19);
    chk("R13 irq off when rx ie clear", irq, 0);
    pop(d); chk("R3 rx byte", d, 8'hA5);
    peek(2'd0, v); chk("R7 full cleared by read", v, 8'h09);

    wr(2'd1, 8'h1A);
    dev_send(8'h3C, 1'b0, 1'b1); wcyc(5);
    chk("R13 irq on rx full", irq, 1);
    pop(d); chk("R3 rx byte 3C", d, 8'h3C);
    wcyc(1); chk("R13 irq drops after read", irq, 0);

    for (int n = 0; n < 16; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      dev_send(r, 1'b0, 1'b1); wcyc(5);
      pop(d); chk("R3 random rx byte", d, r);
    end

    dev_send(8'h55, 1'b1, 1'b1); wcyc(5);
    peek(2'd0, v); chk("R4 parity error flagged", v, 8'h59);
    pop(d); chk("R4 byte kept despite parity", d, 8'h55);
    peek(2'd0, v); chk("R7 parity error cleared", v, 8'h09);

    dev_send(8'h81, 1'b0, 1'b0); wcyc(5);
    peek(2'd0, v); chk("R5 framing error, not full", v, 8'h89);
    chk("R5 no irq without full", irq, 0);
    pop(d);
    peek(2'd0, v); chk("R7 framing error cleared", v, 8'h09);

    dev_bit(1'b0); dev_bit(1'b1); dev_bit(1'b0); dev_bit(1'b1); dev_dat = 1'b1;
    peek(2'd0, v); chk("R6 receive busy mid frame", v, 8'h29);
    wcyc(TO + 50);
    peek(2'd0, v); chk("R6 timeout drops frame", v, 8'h89);
    pop(d);
    dev_send(8'h42, 1'b0, 1'b1); wcyc(5);
    pop(d); chk("R6 recovery after timeout", d, 8'h42);

    dev_send(8'h11, 1'b1, 1'b1); wcyc(5);
    wr(2'd1, 8'h3A); wcyc(10);
    peek(2'd0, v); chk("R12 port reset clears", v, 8'h0A);
    chk("R12 irq low in reset", irq, 0);
    wr(2'd1, 8'h1A); wcyc(10);
    peek(2'd0, v); chk("R12 idle after reset", v, 8'h09);

    wr(2'd1, 8'h0A); wcyc(10);
    chk("R11 pause holds clock", ps2_clk_oe, 1);
    peek(2'd0, v); chk("R11 pause status", v, 8'h0A);

    wr(2'd1, 8'h12);
    wr(2'd2, 8'hC3);
    tx_check(8'hC3, "R9 tx byte C3");

    wr(2'd1, 8'h10);
    wr(2'd2, 8'h77); wcyc(20);
    chk("R8 no start without enable", ps2_clk_oe, 0);
    peek(2'd0, v); chk("R8 write ignored", v, 8'h09);
    wr(2'd1, 8'h12);
    wr(2'd2, 8'hE1); wr(2'd2, 8'h1E);
    tx_check(8'hE1, "R8 second write ignored");

    for (int n = 0; n < 8; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      wr(2'd2, r);
      tx_check(r, "R9 random tx byte");
    end

    wr(2'd1, 8'h16); wcyc(1);
    chk("R13 irq on tx empty", irq, 1);
    wr(2'd2, 8'h5A); wcyc(2);
    chk("R13 irq drops while busy", irq, 0);
    tx_check(8'h5A, "R9 tx byte 5A");
    chk("R13 irq back after tx", irq, 1);

    wr(2'd1, 8'h13);
    wr(2'd2, 8'h99);
    tx_check(8'h99, "R10 tx byte 99");
    wcyc(10);
    chk("R10 clock held after tx", ps2_clk_oe, 1);
    peek(2'd0, v); chk("R10 status shows hold", v, 8'h0A);
    wr(2'd1, 8'h12); wcyc(10);
    chk("R10 hold released", ps2_clk_oe, 0);

    finish_test();
  end
endmodule